// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port Controller

This block holds a set of 8-bit bidirectional ports for a small microcontroller. Each port has an output latch, a direction register (a 1 makes the pin an output) and a per-bit interrupt-enable mask. The CPU reaches the latches and direction registers through a simple 8-bit register interface with a combinational read path and a single-cycle write strobe. Every input pin passes through a two-flop synchronizer before the block uses it.

The block merges two interrupt sources into one external-interrupt latch. The first source is the level-sensitive port interrupt state, which is active while any enabled pin that is an input reads low. The second is the active-low external interrupt pin. Each source sets the latch only on its own inactive-to-active transition, and only while the other source is inactive. The latch drives a pending-request output. The CPU clears the latch with a one-cycle acknowledge pulse when it takes the interrupt.

Two resets are provided. The power-on reset puts the output latches and the sampled inputs at all ones. The ordinary reset clears the direction registers and the interrupt latch, and leaves the latches and the sampled inputs unchanged. The interrupt-enable mask of the second port is loaded from a configuration byte while reset is held. The masks of all other ports load as zero.

Top module: `pioIntTop`

## Requirements
- R1: Address map: addresses 0 to 3 select the data register of ports 0 to 3, and addresses 4 to 7 select the direction register of ports 0 to 3 (address bit 2 picks the direction register). A data read returns, bit by bit, (latch AND dir) OR (syncedInput AND NOT dir). A direction read returns the direction register.
- R2: A write to a data address stores the byte in that port's latch. `pinOut` shows every latch and `pinDir` shows every direction register (port p in bits 8p+7..8p).
- R3: A direction write is ANDed with the mask of bits that exist on that port. Port 3 has no bit 6 (mask 0xBF), so that bit always reads back 0. Ports 0 to 2 use the mask 0xFF.
- R4: `rstN` low clears all direction registers and the interrupt latch, and keeps the output latches and the synced inputs. `porN` low also sets the latches and the synced inputs to 0xFF.
- R5: A change on `pinIn` shows up in data reads and in the interrupt logic two clock edges later (two-flop synchronizer).
- R6: The port interrupt state is the OR over all ports of (enable AND NOT dir AND NOT syncedInput). When it goes from inactive to active while the external pin is inactive, the latch sets and `irqPending` goes to 1.
- R7: A falling edge on `extIrqN`, after synchronization, sets the latch only when the port interrupt state is inactive at that moment.
- R8: A rising port interrupt state does not set the latch while `extIrqN` is held low, and releasing `extIrqN` later does not set it either.
- R9: While reset is held, the enable mask of port 1 loads from `cfgIntEn`, and the masks of the other ports load as zero. The port state is re-evaluated on every change of an input, a direction bit or the mask, so turning an enabled low pin from output to input raises it.
- R10: A cycle with `irqAck` high clears the latch, unless a set condition occurs in the same cycle; a set condition wins.
- R11: A source that stays active sets the latch only once. After an acknowledge the latch stays clear until a new inactive-to-active transition occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset (directions, interrupt latch) |
| porN | input | 1 | Active-low power-on reset (also sets latches and synced inputs to 0xFF) |
| busAddr | input | 3 | Register address |
| busWe | input | 1 | Write strobe, one cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data for `busAddr` |
| pinIn | input | 32 | Pin levels, port p in bits 8p+7..8p |
| pinOut | output | 32 | Output latches |
| pinDir | output | 32 | Direction registers, 1 = output |
| extIrqN | input | 1 | Active-low external interrupt pin |
| cfgIntEn | input | 8 | Enable mask for port 1, loaded while reset is held |
| irqAck | input | 1 | Acknowledge, clears the interrupt latch |
| irqPending | output | 1 | External interrupt request to the CPU |

## Verification
A wrong direction bit shows up right away in `pinDir` and in the data read of that port. A wrong synced input shows up in the data read two edges after the pin changes. A wrong interrupt latch or wrong edge memory shows up at `irqPending` one edge after the synced source changes. It appears either as a missed request or as a second request from a source held at a steady level. The two blocking cases and the acknowledge race are each driven on purpose, so that an error in which source wins is seen within a few cycles.

// File: rtl/pioIntPkg.sv
package pioIntPkg;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic             wrLatch;
    logic             wrDdr;
    logic             rdDdr;
    logic [SEL_W-1:0] portSel;
  } busStrobeT;
endpackage

// File: rtl/pioIntData.sv
module pioIntData
  import pioIntPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W = 8,
  parameter logic [NUM_PORTS*PORT_W-1:0] PRESENT_MASKS = 32'hBFFF_FFFF,
  parameter int IE_CFG_PORT = 1
) (
  input  logic                        clk,
  input  logic                        sysRstN,
  input  logic                        porN,
  input  busStrobeT                   strb,
  input  logic [PORT_W-1:0]           busWdata,
  output logic [PORT_W-1:0]           busRdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pinIn,
  output logic [NUM_PORTS*PORT_W-1:0] pinOut,
  output logic [NUM_PORTS*PORT_W-1:0] pinDir,
  input  logic [PORT_W-1:0]           cfgIntEn,
  output logic                        portIrq
);
  localparam int IDX_W = $clog2(NUM_PORTS);

  logic [PORT_W-1:0] latchQ [NUM_PORTS];
  logic [PORT_W-1:0] ddrQ   [NUM_PORTS];
  logic [PORT_W-1:0] ieQ    [NUM_PORTS];
  logic [PORT_W-1:0] sync1Q [NUM_PORTS];
  logic [PORT_W-1:0] inSync [NUM_PORTS];
  logic [NUM_PORTS-1:0] portTerm;
  logic [IDX_W-1:0] idx;

  assign idx = strb.portSel[IDX_W-1:0];

  // Latches and synchronizer survive ordinary reset; only power-on sets them.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        latchQ[p] <= '1;
        sync1Q[p] <= '1;
        inSync[p] <= '1;
      end
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        sync1Q[p] <= pinIn[p*PORT_W +: PORT_W];
        inSync[p] <= sync1Q[p];
        if (strb.wrLatch && (idx == IDX_W'(p))) latchQ[p] <= busWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      for (int p = 0; p < NUM_PORTS; p++) ddrQ[p] <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (strb.wrDdr && (idx == IDX_W'(p)))
          ddrQ[p] <= busWdata & PRESENT_MASKS[p*PORT_W +: PORT_W];
    end
  end

  // Enable masks are configuration: sampled on every clock while reset is held.
  always_ff @(posedge clk) begin
    if (!sysRstN) begin
      for (int p = 0; p < NUM_PORTS; p++)
        ieQ[p] <= (p == IE_CFG_PORT) ? cfgIntEn : '0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PORTS; g++) begin : gPort
      assign pinOut[g*PORT_W +: PORT_W] = latchQ[g];
      assign pinDir[g*PORT_W +: PORT_W] = ddrQ[g];
      assign portTerm[g] = |(ieQ[g] & ~ddrQ[g] & ~inSync[g]);

      AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!sysRstN)
        (strb.wrLatch && strb.portSel == SEL_W'(g)) |=> latchQ[g] == $past(busWdata)); // R2
      AST_DDR_MASKED: assert property (@(posedge clk) disable iff (!sysRstN)
        (strb.wrDdr && strb.portSel == SEL_W'(g)) |=>
          ddrQ[g] == ($past(busWdata) & PRESENT_MASKS[g*PORT_W +: PORT_W])); // R3
    end
  endgenerate

  assign portIrq = |portTerm;

  always_comb begin
    if (strb.rdDdr) busRdata = ddrQ[idx];
    else busRdata = (latchQ[idx] & ddrQ[idx]) | (inSync[idx] & ~ddrQ[idx]);
  end
endmodule

// File: rtl/pioIntCtrl.sv
module pioIntCtrl
  import pioIntPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              extIrqN,
  input  logic              portIrq,
  input  logic              irqAck,
  output busStrobeT         strb,
  output logic              irqPending
);
  logic extSync1, extSync2, extPrev, portPrev, irqLatch;
  logic extActive, extRise, portRise, setReq;

  always_comb begin
    strb.wrLatch = busWe & ~busAddr[ADDR_W-1];
    strb.wrDdr   = busWe &  busAddr[ADDR_W-1];
    strb.rdDdr   = busAddr[ADDR_W-1];
    strb.portSel = SEL_W'(busAddr[ADDR_W-2:0]);
  end

  assign extActive = ~extSync2;
  assign extRise   = extActive & ~extPrev;
  assign portRise  = portIrq & ~portPrev;
  assign setReq    = (extRise & ~portIrq) | (portRise & ~extActive);

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      extSync1 <= 1'b1;
      extSync2 <= 1'b1;
      extPrev  <= 1'b0;
      portPrev <= 1'b0;
      irqLatch <= 1'b0;
    end else begin
      extSync1 <= extIrqN;
      extSync2 <= extSync1;
      extPrev  <= extActive;
      portPrev <= portIrq;
      if (setReq) irqLatch <= 1'b1;
      else if (irqAck) irqLatch <= 1'b0;
    end
  end

  assign irqPending = irqLatch;

  AST_PORT_SETS: assert property (@(posedge clk) disable iff (!sysRstN)
    (portRise && !extActive) |=> irqPending); // R6
  AST_EXT_BLOCKED: assert property (@(posedge clk) disable iff (!sysRstN)
    (extRise && portIrq && !irqAck) |=> $stable(irqPending)); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!sysRstN)
    (irqAck && !portRise && !extRise) |=> !irqPending); // R10
  AST_NO_SET_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!sysRstN)
    (!irqPending && !portRise && !extRise) |=> !irqPending); // R11
endmodule

// File: rtl/pioIntTop.sv
module pioIntTop
  import pioIntPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W = 8,
  parameter logic [NUM_PORTS*PORT_W-1:0] PRESENT_MASKS = 32'hBFFF_FFFF,
  parameter int IE_CFG_PORT = 1,
  localparam int ADDR_W = $clog2(NUM_PORTS) + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        porN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWe,
  input  logic [PORT_W-1:0]           busWdata,
  output logic [PORT_W-1:0]           busRdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pinIn,
  output logic [NUM_PORTS*PORT_W-1:0] pinOut,
  output logic [NUM_PORTS*PORT_W-1:0] pinDir,
  input  logic                        extIrqN,
  input  logic [PORT_W-1:0]           cfgIntEn,
  input  logic                        irqAck,
  output logic                        irqPending
);
  logic sysRstN, portIrq;
  busStrobeT strb;

  assign sysRstN = rstN & porN;

  pioIntCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .sysRstN(sysRstN), .busAddr(busAddr), .busWe(busWe),
    .extIrqN(extIrqN), .portIrq(portIrq), .irqAck(irqAck),
    .strb(strb), .irqPending(irqPending)
  );

  pioIntData #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
    .PRESENT_MASKS(PRESENT_MASKS), .IE_CFG_PORT(IE_CFG_PORT)
  ) data_i (
    .clk(clk), .sysRstN(sysRstN), .porN(porN), .strb(strb),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinDir(pinDir), .cfgIntEn(cfgIntEn), .portIrq(portIrq)
  );
endmodule

// File: tb/pioIntTop_tb_top.sv
`timescale 1ns/1ps
module pioIntTop_tb_top;
  logic clk = 1'b0;
  logic rstN, porN, busWe, extIrqN, irqAck, irqPending;
  logic [2:0] busAddr;
  logic [7:0] busWdata, busRdata, cfgIntEn;
  logic [31:0] pinIn, pinOut, pinDir;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pioIntTop dut_i (
    .clk(clk), .rstN(rstN), .porN(porN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinDir(pinDir), .extIrqN(extIrqN), .cfgIntEn(cfgIntEn), .irqAck(irqAck),
    .irqPending(irqPending)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    busAddr = a;
    #0.5;
    chk(req, {24'h0, busRdata}, {24'h0, exp});
  endtask

  task automatic setPin(input int p, input logic [7:0] v);
    pinIn[p*8 +: 8] = v;
  endtask

  task automatic ackPulse();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic tReset();
    chk("R4 power-on latches", pinOut, 32'hFFFF_FFFF);
    chk("R4 power-on dirs", pinDir, 32'h0);
    chk("R4 power-on pending", {31'h0, irqPending}, 32'h0);
  endtask

  task automatic tReadMux();
    wr(3'd4, 8'hF0);
    wr(3'd0, 8'hA5);
    setPin(0, 8'h3C);
    clks(3);
    rdChk("R1 mixed read", 3'd0, 8'hAC);
    rdChk("R1 dir read", 3'd4, 8'hF0);
    chk("R2 pinOut", {24'h0, pinOut[7:0]}, 32'hA5);
    chk("R2 pinDir", {24'h0, pinDir[7:0]}, 32'hF0);
  endtask

  task automatic tMask();
    wr(3'd7, 8'hFF);
    rdChk("R3 absent bit", 3'd7, 8'hBF);
    chk("R3 pinDir port3", {24'h0, pinDir[31:24]}, 32'hBF);
    wr(3'd6, 8'hFF);
    rdChk("R3 full port", 3'd6, 8'hFF);
    wr(3'd7, 8'h00);
    wr(3'd6, 8'h00);
  endtask

  task automatic tSync();
    wr(3'd4, 8'h00);
    clks(1);
    @(negedge clk); setPin(0, 8'h11);
    @(posedge clk); @(negedge clk);
    busAddr = 3'd0; #0.5;
    chk("R5 one edge old", {24'h0, busRdata}, 32'h3C);
    @(posedge clk); @(negedge clk);
    busAddr = 3'd0; #0.5;
    chk("R5 two edges new", {24'h0, busRdata}, 32'h11);
    setPin(0, 8'hFF);
  endtask

  task automatic tPortIrq();
    setPin(0, 8'h00);
    clks(4);
    chk("R9 port0 disabled", {31'h0, irqPending}, 32'h0);
    setPin(0, 8'hFF);
    wr(3'd5, 8'h01);
    setPin(1, 8'hFE);
    clks(4);
    chk("R9 output bit masked", {31'h0, irqPending}, 32'h0);
    wr(3'd5, 8'h00);
    clks(2);
    chk("R6 R9 dir change raises", {31'h0, irqPending}, 32'h1);
  endtask

  task automatic tAck();
    ackPulse();
    clks(3);
    chk("R10 R11 ack clears, level no retrigger", {31'h0, irqPending}, 32'h0);
    setPin(1, 8'hFF);
    clks(4);
    @(negedge clk); setPin(1, 8'hFE);
    @(posedge clk); @(posedge clk); @(negedge clk);
    irqAck = 1'b1;
    @(posedge clk); @(negedge clk);
    irqAck = 1'b0;
    chk("R10 set wins over ack", {31'h0, irqPending}, 32'h1);
    ackPulse();
    setPin(1, 8'hFF);
    clks(4);
  endtask

  task automatic tExt();
    extIrqN = 1'b0;
    clks(3);
    chk("R7 ext edge sets", {31'h0, irqPending}, 32'h1);
    ackPulse();
    clks(3);
    chk("R11 ext held no retrigger", {31'h0, irqPending}, 32'h0);
    extIrqN = 1'b1;
    clks(3);
    setPin(1, 8'hFE);
    clks(3);
    ackPulse();
    extIrqN = 1'b0;
    clks(4);
    chk("R7 ext blocked by port", {31'h0, irqPending}, 32'h0);
  endtask

  task automatic tPortBlocked();
    setPin(1, 8'hFF);
    clks(3);
    setPin(1, 8'hFE);
    clks(4);
    chk("R8 port blocked by ext", {31'h0, irqPending}, 32'h0);
    extIrqN = 1'b1;
    clks(4);
    chk("R8 ext release no set", {31'h0, irqPending}, 32'h0);
    setPin(1, 8'hFF);
    clks(3);
  endtask

  task automatic tResetKeep();
    wr(3'd0, 8'h5A);
    wr(3'd4, 8'hFF);
    setPin(0, 8'h33);
    extIrqN = 1'b0;
    clks(3);
    extIrqN = 1'b1;
    chk("R7 pending before reset", {31'h0, irqPending}, 32'h1);
    rstN = 1'b0;
    clks(2);
    rstN = 1'b1;
    clks(2);
    chk("R4 pending cleared", {31'h0, irqPending}, 32'h0);
    chk("R4 dirs cleared", pinDir, 32'h0);
    chk("R4 latch kept", {24'h0, pinOut[7:0]}, 32'h5A);
    rdChk("R4 input read after reset", 3'd0, 8'h33);
  endtask

  initial begin
    porN = 1'b0; rstN = 1'b0; busWe = 1'b0; busAddr = 3'd0; busWdata = 8'h0;
    pinIn = 32'hFFFF_FFFF; extIrqN = 1'b1; cfgIntEn = 8'h0F; irqAck = 1'b0;
    clks(5);
    porN = 1'b1; rstN = 1'b1;
    clks(3);
    tReset();
    tReadMux();
    tMask();
    tSync();
    tPortIrq();
    tAck();
    tExt();
    tPortBlocked();
    tResetKeep();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule